// File: doc/BRIEF.md
# Oscillator Band Search Controller

This controller finds a working oscillator setting for a frequency synthesizer that offers several oscillators, each with a set of sub-bands. The caller pulses `start_i` and supplies three things: an initial oscillator and sub-band, a post-divider selection and a settle time. The controller then runs trials. For each trial it presents the setting on registered outputs and strobes `apply_o` for one cycle. It waits for the settle counter to run out, raises `code_req_o`, and accepts a 3-bit lock code once `code_valid_i` is asserted.

Oscillator and sub-band together form one linear index: oscillator × 8 + sub-band, which is `{osc, sub}`. A code of all zeros moves the index one step down. A code of all ones moves it one step up. Any other code ends the search at once with the current setting and reports it as locked. There is no search for a better setting. The search stops with a failure in two cases: a step would leave the legal index range, or the step direction reverses. The done, locked and fail flags stay at their values until the next start.

Top module: `vband_search_top`

## Requirements
- R1: After synchronous reset the block is idle: `done_o`, `locked_o`, `fail_o`, `apply_o`, `code_req_o` and `busy_o` are all 0.
- R2: A `start_i` pulse while idle clears all three flags. From the next cycle, `osc_o`/`sub_o` show the initial setting and `apply_o` is high for exactly one cycle.
- R3: `code_req_o` rises exactly `settle_cycles_i`+1 cycles after each `apply_o` strobe. It stays high until a code is accepted.
- R4: A lock code is sampled only in a cycle where `code_req_o` and `code_valid_i` are both high. A code presented with `code_valid_i` low changes nothing.
- R5: A code from 3'b001 to 3'b110 inclusive ends the search with `done_o`=1, `locked_o`=1 and `fail_o`=0, and the setting unchanged.
- R6: Code 3'b000 lowers the index by one on the next cycle together with a new `apply_o` strobe. Sub-band 0 of oscillator k moves to sub-band 7 of oscillator k-1.
- R7: Code 3'b111 raises the index by one on the next cycle together with a new `apply_o` strobe. Sub-band 7 of oscillator k moves to sub-band 0 of oscillator k+1.
- R8: Code 3'b000 at index 0, or code 3'b111 at index 23, ends the search with `done_o`=1 and `fail_o`=1, and the setting is kept.
- R9: A step opposite in direction to the previous step of the same search ends it with `done_o`=1 and `fail_o`=1. Examples are 3'b000 after 3'b111, or 3'b111 after 3'b000.
- R10: `div_o` takes the value of `div_sel_i` at start and holds it for the whole search.
- R11: `start_i` has no effect while `busy_o` is high.
- R12: A start with oscillator field 3 (index above 23) ends at once with `done_o`=1 and `fail_o`=1. No `apply_o` strobe and no code request follow.
- R13: The flags hold their final values while idle, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, honoured only while idle |
| init_osc_i | input | 2 | Initial oscillator number |
| init_sub_i | input | 3 | Initial sub-band number |
| div_sel_i | input | 2 | Post-divider select (ratio 4, 8, 16, 32) |
| settle_cycles_i | input | 8 | Settle wait after each apply, in cycles minus one |
| code_valid_i | input | 1 | Lock code valid |
| code_i | input | 3 | Lock code |
| code_req_o | output | 1 | Lock code requested |
| osc_o | output | 2 | Current oscillator |
| sub_o | output | 3 | Current sub-band |
| div_o | output | 2 | Post-divider select in force |
| apply_o | output | 1 | One-cycle strobe: write the setting to the synthesizer |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Search finished |
| locked_o | output | 1 | Finished with a locking setting |
| fail_o | output | 1 | Finished without lock |

## Verification
The bench sweeps every initial index against every lock position, so stepping in both directions and the carry and borrow across oscillators at sub-band 7/0 are all covered. A wrong carry or borrow would show up as a skipped or repeated setting. The bench hits both range ends and both orders of direction reversal. A design that got these wrong would wrap from index 0 to 23, run past the top, or bounce between two settings forever. In every trial the bench also offers invalid codes and extra start pulses, and measures the exact settle delay, so an off-by-one in the timer or a search restarted mid-trial would show up.

// File: rtl/vband_pkg.sv
package vband_pkg;

    localparam int CODE_W = 3;
    localparam logic [CODE_W-1:0] CODE_AT_BOTTOM = 3'b000;
    localparam logic [CODE_W-1:0] CODE_AT_TOP    = 3'b111;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_QUERY  = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_DOWN = 2'd1,
        DIR_UP   = 2'd2
    } dir_e;

    typedef enum logic [1:0] {
        ACT_LOCK = 2'd0,
        ACT_STEP = 2'd1,
        ACT_FAIL = 2'd2
    } act_e;

    typedef struct packed {
        act_e act;
        dir_e dir;
    } step_ctl_t;

    function automatic logic code_is_lock(input logic [CODE_W-1:0] code);
        return (code != CODE_AT_BOTTOM) && (code != CODE_AT_TOP);
    endfunction

endpackage

// File: rtl/vband_settle_timer.sv
module vband_settle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] count_i,
    input  logic         run_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= count_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/vband_step_unit.sv
module vband_step_unit
    import vband_pkg::*;
#(
    parameter int IDX_W    = 5,
    parameter int LAST_IDX = 23
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [CODE_W-1:0] code_i,
    input  dir_e              dir_i,
    output step_ctl_t         ctl_o,
    output logic [IDX_W-1:0]  idx_next_o
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(LAST_IDX);

    always_comb begin
        ctl_o.act  = ACT_LOCK;
        ctl_o.dir  = dir_i;
        idx_next_o = idx_i;
        if (code_i == CODE_AT_BOTTOM) begin
            ctl_o.dir = DIR_DOWN;
            if ((dir_i == DIR_UP) || (idx_i == '0)) begin
                ctl_o.act = ACT_FAIL;
            end else begin
                ctl_o.act  = ACT_STEP;
                idx_next_o = idx_i - IDX_W'(1);
            end
        end else if (code_i == CODE_AT_TOP) begin
            ctl_o.dir = DIR_UP;
            if ((dir_i == DIR_DOWN) || (idx_i >= TOP_IDX)) begin
                ctl_o.act = ACT_FAIL;
            end else begin
                ctl_o.act  = ACT_STEP;
                idx_next_o = idx_i + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/vband_search_top.sv
module vband_search_top
    import vband_pkg::*;
#(
    parameter int OSC_COUNT = 3,
    parameter int OSC_W     = 2,
    parameter int SUB_W     = 3,
    parameter int DIV_W     = 2,
    parameter int SETTLE_W  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [OSC_W-1:0]    init_osc_i,
    input  logic [SUB_W-1:0]    init_sub_i,
    input  logic [DIV_W-1:0]    div_sel_i,
    input  logic [SETTLE_W-1:0] settle_cycles_i,
    input  logic                code_valid_i,
    input  logic [CODE_W-1:0]   code_i,
    output logic                code_req_o,
    output logic [OSC_W-1:0]    osc_o,
    output logic [SUB_W-1:0]    sub_o,
    output logic [DIV_W-1:0]    div_o,
    output logic                apply_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                locked_o,
    output logic                fail_o
);
    localparam int IDX_W    = OSC_W + SUB_W;
    localparam int LAST_IDX = OSC_COUNT * (1 << SUB_W) - 1;

    state_e            state_q;
    dir_e              dir_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DIV_W-1:0]  div_q;
    logic              apply_q;
    logic              done_q;
    logic              locked_q;
    logic              fail_q;

    logic              init_legal;
    logic              accept_start;
    logic              take_code;
    logic              launch;
    logic              settled;
    step_ctl_t         ctl;
    logic [IDX_W-1:0]  idx_next;

    assign init_legal   = (int'(init_osc_i) < OSC_COUNT);
    assign accept_start = (state_q == ST_IDLE) && start_i;
    assign take_code    = (state_q == ST_QUERY) && code_valid_i;
    assign launch       = (accept_start && init_legal) ||
                          (take_code && (ctl.act == ACT_STEP));

    vband_step_unit #(
        .IDX_W    (IDX_W),
        .LAST_IDX (LAST_IDX)
    ) step_i (
        .idx_i      (idx_q),
        .code_i     (code_i),
        .dir_i      (dir_q),
        .ctl_o      (ctl),
        .idx_next_o (idx_next)
    );

    vband_settle_timer #(
        .W (SETTLE_W)
    ) timer_i (
        .clk       (clk),
        .rst       (rst),
        .load_i    (launch),
        .count_i   (settle_cycles_i),
        .run_i     (state_q == ST_SETTLE),
        .expired_o (settled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            dir_q    <= DIR_NONE;
            idx_q    <= '0;
            div_q    <= '0;
            apply_q  <= 1'b0;
            done_q   <= 1'b0;
            locked_q <= 1'b0;
            fail_q   <= 1'b0;
        end else begin
            apply_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        locked_q <= 1'b0;
                        dir_q    <= DIR_NONE;
                        div_q    <= div_sel_i;
                        idx_q    <= {init_osc_i, init_sub_i};
                        if (init_legal) begin
                            done_q  <= 1'b0;
                            fail_q  <= 1'b0;
                            apply_q <= 1'b1;
                            state_q <= ST_SETTLE;
                        end else begin
                            done_q <= 1'b1;
                            fail_q <= 1'b1;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (settled) begin
                        state_q <= ST_QUERY;
                    end
                end
                ST_QUERY: begin
                    if (code_valid_i) begin
                        unique case (ctl.act)
                            ACT_LOCK: begin
                                done_q   <= 1'b1;
                                locked_q <= 1'b1;
                                state_q  <= ST_IDLE;
                            end
                            ACT_STEP: begin
                                idx_q   <= idx_next;
                                dir_q   <= ctl.dir;
                                apply_q <= 1'b1;
                                state_q <= ST_SETTLE;
                            end
                            default: begin
                                done_q  <= 1'b1;
                                fail_q  <= 1'b1;
                                state_q <= ST_IDLE;
                            end
                        endcase
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign code_req_o = (state_q == ST_QUERY);
    assign busy_o     = (state_q != ST_IDLE);
    assign osc_o      = idx_q[IDX_W-1:SUB_W];
    assign sub_o      = idx_q[SUB_W-1:0];
    assign div_o      = div_q;
    assign apply_o    = apply_q;
    assign done_o     = done_q;
    assign locked_o   = locked_q;
    assign fail_o     = fail_q;

    AST_APPLY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        apply_o |=> !apply_o);  // R2

    AST_NO_REQ_WITH_APPLY: assert property (@(posedge clk) disable iff (rst)
        apply_o |-> !code_req_o);  // R3

    AST_LOCK_ENDS: assert property (@(posedge clk) disable iff (rst)
        (code_req_o && code_valid_i && code_is_lock(code_i))
        |=> (done_o && locked_o && !fail_o && $stable(idx_q)));  // R5

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (code_req_o && code_valid_i && (code_i == CODE_AT_BOTTOM))
        |=> (fail_o || (idx_q == $past(idx_q) - IDX_W'(1))));  // R6

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (code_req_o && code_valid_i && (code_i == CODE_AT_TOP))
        |=> (fail_o || (idx_q == $past(idx_q) + IDX_W'(1))));  // R7

    AST_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (int'(idx_q) <= LAST_IDX));  // R8

    AST_DIV_HELD: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(div_o));  // R10

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !code_valid_i) |=> ($stable(idx_q) && !done_o));  // R11

    AST_BAD_INIT: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && (int'(init_osc_i) >= OSC_COUNT))
        |=> (done_o && fail_o && !apply_o));  // R12

    AST_FLAG_IMPLIES_DONE: assert property (@(posedge clk) disable iff (rst)
        (locked_o || fail_o) |-> (done_o && !(locked_o && fail_o)));  // R13

endmodule

// File: tb/vband_search_top_tb_top.sv
module vband_search_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [1:0] init_osc_i = '0;
    logic [2:0] init_sub_i = '0;
    logic [1:0] div_sel_i = '0;
    logic [7:0] settle_cycles_i = '0;
    logic       code_valid_i = 1'b0;
    logic [2:0] code_i = '0;
    logic       code_req_o;
    logic [1:0] osc_o;
    logic [2:0] sub_o;
    logic [1:0] div_o;
    logic       apply_o;
    logic       busy_o;
    logic       done_o;
    logic       locked_o;
    logic       fail_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    vband_search_top dut_i (
        .clk             (clk),
        .rst             (rst),
        .start_i         (start_i),
        .init_osc_i      (init_osc_i),
        .init_sub_i      (init_sub_i),
        .div_sel_i       (div_sel_i),
        .settle_cycles_i (settle_cycles_i),
        .code_valid_i    (code_valid_i),
        .code_i          (code_i),
        .code_req_o      (code_req_o),
        .osc_o           (osc_o),
        .sub_o           (sub_o),
        .div_o           (div_o),
        .apply_o         (apply_o),
        .busy_o          (busy_o),
        .done_o          (done_o),
        .locked_o        (locked_o),
        .fail_o          (fail_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int cur_idx();
        return int'({osc_o, sub_o});
    endfunction

    // mode 0: lock at tgt only; 1: always top code; 2: always bottom code;
    // 3: top then bottom; 4: bottom then top
    task automatic run_search(input int init, input int tgt, input int mode,
                              input int settle, input int dv);
        int e;
        int last;   // 0 none, 1 down, 2 up
        int trials;
        int cyc;
        bit fin;
        logic [2:0] c;
        e = init; last = 0; trials = 0; fin = 0;
        @(negedge clk);
        start_i = 1'b1;
        init_osc_i = 2'(init / 8);
        init_sub_i = 3'(init % 8);
        settle_cycles_i = 8'(settle);
        div_sel_i = 2'(dv);
        @(negedge clk);
        start_i = 1'b0;
        check(!done_o && !locked_o && !fail_o, "R13 flags cleared by start",
              int'({done_o, locked_o, fail_o}), 0);
        while (!fin) begin
            check(apply_o == 1'b1, "R2 apply strobe", int'(apply_o), 1);
            check(cur_idx() == e, "R2 R6 R7 setting", cur_idx(), e);
            check(div_o == 2'(dv), "R10 divider", int'(div_o), dv);
            cyc = 0;
            while (!code_req_o && cyc < 300) begin
                @(negedge clk);
                cyc++;
            end
            check(cyc == settle + 1, "R3 settle delay", cyc, settle + 1);
            code_i = (e % 2 == 0) ? 3'b000 : 3'b111;
            code_valid_i = 1'b0;
            start_i = 1'b1;
            init_osc_i = 2'd0;
            init_sub_i = 3'(e + 3);
            @(negedge clk);
            start_i = 1'b0;
            check(code_req_o && !apply_o && !done_o && cur_idx() == e,
                  "R4 R11 idle cycle", cur_idx(), e);
            case (mode)
                0:       c = (e == tgt) ? 3'(1 + e % 6) : ((e < tgt) ? 3'b111 : 3'b000);
                1:       c = 3'b111;
                2:       c = 3'b000;
                3:       c = (trials == 0) ? 3'b111 : 3'b000;
                default: c = (trials == 0) ? 3'b000 : 3'b111;
            endcase
            code_i = c;
            code_valid_i = 1'b1;
            @(negedge clk);
            code_valid_i = 1'b0;
            code_i = 3'b111;
            trials++;
            if (c != 3'b000 && c != 3'b111) begin
                check(done_o && locked_o && !fail_o && cur_idx() == e,
                      "R5 locked result", cur_idx(), e);
                fin = 1;
            end else if (c == 3'b000) begin
                if (last == 2) begin
                    check(done_o && fail_o && !locked_o && !apply_o && cur_idx() == e,
                          "R9 reversal down", int'({done_o, fail_o}), 3);
                    fin = 1;
                end else if (e == 0) begin
                    check(done_o && fail_o && !locked_o && cur_idx() == e,
                          "R8 below range", int'({done_o, fail_o}), 3);
                    fin = 1;
                end else begin
                    e--; last = 1;
                end
            end else begin
                if (last == 1) begin
                    check(done_o && fail_o && !locked_o && !apply_o && cur_idx() == e,
                          "R9 reversal up", int'({done_o, fail_o}), 3);
                    fin = 1;
                end else if (e == 23) begin
                    check(done_o && fail_o && !locked_o && cur_idx() == e,
                          "R8 above range", int'({done_o, fail_o}), 3);
                    fin = 1;
                end else begin
                    e++; last = 2;
                end
            end
        end
        repeat (3) @(negedge clk);
        check(done_o && !busy_o && !code_req_o && !apply_o,
              "R13 flags hold while idle", int'({done_o, busy_o}), 2);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!done_o && !locked_o && !fail_o && !apply_o && !code_req_o && !busy_o,
              "R1 reset state",
              int'({done_o, locked_o, fail_o, apply_o, code_req_o, busy_o}), 0);

        for (int init = 0; init < 24; init++) begin
            for (int tgt = 0; tgt < 24; tgt++) begin
                run_search(init, tgt, 0, (init + tgt) % 3, (init + tgt) % 4);
            end
        end

        run_search(5, 0, 2, 1, 2);
        run_search(20, 0, 1, 0, 1);
        run_search(0, 0, 2, 2, 3);
        run_search(23, 0, 1, 1, 0);
        run_search(10, 0, 3, 0, 2);
        run_search(10, 0, 4, 1, 3);
        run_search(8, 0, 4, 0, 1);
        run_search(7, 0, 3, 2, 0);
        run_search(12, 12, 0, 20, 3);

        @(negedge clk);
        start_i = 1'b1;
        init_osc_i = 2'd3;
        init_sub_i = 3'd2;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o && fail_o && !locked_o && !apply_o,
              "R12 illegal start", int'({done_o, fail_o, apply_o}), 6);
        repeat (3) @(negedge clk);
        check(!code_req_o && !apply_o && !busy_o && done_o && fail_o,
              "R12 no trial follows", int'({code_req_o, apply_o, busy_o}), 0);

        run_search(3, 9, 0, 0, 1);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!done_o && !locked_o && !fail_o && !busy_o, "R1 reset clears flags",
              int'({done_o, locked_o, fail_o}), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule